// File: doc/BRIEF.md
# Packet Buffer Page Manager

This block owns the page pool of a packet-buffer network controller. A host writes 3-bit operation codes into a command register. It can claim a group of buffer pages for a new packet, hand back every page that a packet holds, put a packet number on the transmit queue, or flush the transmit queues. The packet number used by release and enqueue comes from a separate packet number input that the host loads before it issues the command.

Each page carries a used bit and the number of the packet that owns it. A packet is named by the index of the lowest page it took. Allocation and release both walk the page map one page per clock. A release raises BUSY for the whole walk. An allocation raises FAILED as soon as it is accepted and drops it when the packet number is ready. The transmit side has two small FIFOs. The pending queue is filled by enqueue commands and drained by the MAC. The completion queue is filled by the MAC and read back by the host.

Top module: `pkt_mmu`

## Requirements
- R1: A command acts only when the write strobe falls. The operation code is `cmd_wdata[7:5]` and bits [4:0] are ignored. While the strobe is held high, `busy` and `failed` keep their values.
- R2: Code 3'b001 sets `failed` one cycle after the strobe falls. If at least ALLOC_PAGES pages are free, ALLOC_PAGES cycles later `failed` clears, `alloc_pkt` shows the lowest free page index, and `alloc_irq` pulses for one cycle.
- R3: If fewer than ALLOC_PAGES pages are free, an allocation leaves `failed` high, gives no `alloc_irq`, and changes no page.
- R4: Code 3'b101 frees every page owned by `pnr`, one per cycle. With k owned pages, `busy` is high for k+1 cycles starting one cycle after the strobe falls.
- R5: An allocate or release issued while an earlier allocate or release is still walking has no effect, and neither does a release of a packet that owns no page. Each of these sets the sticky `err_flag`.
- R6: Code 3'b110 appends `pnr` to the pending queue. `tx_head` presents entries in arrival order, and `tx_pop` advances it.
- R7: An enqueue into a full pending queue is dropped and sets the sticky `tx_ovf`.
- R8: Code 3'b111 empties both the pending queue and the completion queue, and leaves page ownership unchanged.
- R9: The completion queue stores `cmpl_din` on `cmpl_push`. The host sees entries on `cmpl_head` in order and advances with `cmpl_rd`.
- R10: Codes 3'b000, 3'b010, 3'b011 and 3'b100 change no output and no page.
- R11: After reset, `busy`, `failed`, `alloc_irq`, `err_flag` and `tx_ovf` are low, both queues are empty, and every page is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cmd_wr | input | 1 | command write strobe |
| cmd_wdata | input | CMD_W | command word, opcode in the top three bits |
| pnr | input | PN_W | packet number register |
| busy | output | 1 | release walk in progress |
| failed | output | 1 | allocation pending or unsuccessful |
| alloc_pkt | output | PN_W | packet number of the last successful allocation |
| alloc_irq | output | 1 | one-cycle allocation-done pulse |
| err_flag | output | 1 | sticky: a command was rejected |
| tx_ovf | output | 1 | sticky: an enqueue was dropped |
| tx_pop | input | 1 | MAC takes the pending queue head |
| tx_head | output | PN_W | packet number at the head of the pending queue |
| tx_empty | output | 1 | pending queue empty |
| cmpl_push | input | 1 | MAC writes a completed packet number |
| cmpl_din | input | PN_W | completed packet number |
| cmpl_rd | input | 1 | host takes the completion queue head |
| cmpl_head | output | PN_W | head of the completion queue |
| cmpl_empty | output | 1 | completion queue empty |

## Verification
The assertions assume that the strobe is a level held for whole cycles. They also assume `tx_pop` and `cmpl_rd` are asserted only while the matching queue has data, and that `pnr` stays steady across the cycle in which a command is accepted. The bench drives every input on the falling clock edge and holds the strobe for one to three cycles. It pops and reads only when its own model shows a queue is non-empty. Apart from the one directed collision case, it waits for a walk to finish before it issues the next allocate or release.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;
  localparam logic [2:0] OP_ALLOC = 3'b001;
  localparam logic [2:0] OP_FREE  = 3'b101;
  localparam logic [2:0] OP_ENQ   = 3'b110;
  localparam logic [2:0] OP_QCLR  = 3'b111;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ALLOC = 2'd1,
    ENG_FREE  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/pkt_mmu_fifo.sv
module pkt_mmu_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp[AW-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  // R7: fill level never goes past the depth
  a_r7_level_bounded: assert property (@(posedge clk) disable iff (rst)
    (wp - rp) <= (AW+1)'(DEPTH));
  // R7: a push into a full queue without a pop leaves it full
  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> full);
  // R8: a flush leaves the queue empty
  a_r8_clr_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);
endmodule

// File: rtl/pkt_mmu_pages.sv
module pkt_mmu_pages
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int ALLOC_PAGES = 2,
  localparam int PN_W       = $clog2(NUM_PAGES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_alloc,
  input  logic            start_free,
  input  logic [PN_W-1:0] free_pkt,
  output logic            busy,
  output logic            failed,
  output logic [PN_W-1:0] alloc_pkt,
  output logic            alloc_irq,
  output logic            err
);
  localparam int CNT_W = $clog2(NUM_PAGES + 1);
  localparam int ACW   = $clog2(ALLOC_PAGES + 1);

  eng_state_e      state;
  logic [NUM_PAGES-1:0] used;
  logic [PN_W-1:0] owner [NUM_PAGES];
  logic [PN_W-1:0] tgt, cmp_pkt, ff_idx, hit_idx;
  logic            hit_any;
  logic [CNT_W-1:0] free_cnt;
  logic [ACW-1:0]  taken;

  // lowest free page, lowest page of the compared packet, free count
  always_comb begin
    cmp_pkt  = (state == ENG_IDLE) ? free_pkt : tgt;
    ff_idx   = '0;
    hit_idx  = '0;
    hit_any  = 1'b0;
    free_cnt = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!used[i]) ff_idx = PN_W'(i);
      if (used[i] && owner[i] == cmp_pkt) begin
        hit_any = 1'b1;
        hit_idx = PN_W'(i);
      end
    end
    for (int i = 0; i < NUM_PAGES; i++)
      free_cnt = free_cnt + CNT_W'(!used[i]);
  end

  always_ff @(posedge clk) begin
    if (state == ENG_ALLOC) owner[ff_idx] <= tgt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      used      <= '0;
      busy      <= 1'b0;
      failed    <= 1'b0;
      alloc_pkt <= '0;
      alloc_irq <= 1'b0;
      err       <= 1'b0;
      tgt       <= '0;
      taken     <= '0;
    end else begin
      alloc_irq <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start_alloc) begin
            failed <= 1'b1;
            if (free_cnt >= CNT_W'(ALLOC_PAGES)) begin
              state <= ENG_ALLOC;
              tgt   <= ff_idx;
              taken <= '0;
            end
          end else if (start_free) begin
            if (hit_any) begin
              state <= ENG_FREE;
              busy  <= 1'b1;
              tgt   <= free_pkt;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ENG_ALLOC: begin
          used[ff_idx] <= 1'b1;
          taken        <= taken + 1'b1;
          if (taken == ACW'(ALLOC_PAGES - 1)) begin
            state     <= ENG_IDLE;
            failed    <= 1'b0;
            alloc_pkt <= tgt;
            alloc_irq <= 1'b1;
          end
          if (start_alloc || start_free) err <= 1'b1;
        end
        ENG_FREE: begin
          if (hit_any) begin
            used[hit_idx] <= 1'b0;
          end else begin
            state <= ENG_IDLE;
            busy  <= 1'b0;
          end
          if (start_alloc || start_free) err <= 1'b1;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R2: the completion pulse only comes with a cleared FAILED
  a_r2_irq_with_success: assert property (@(posedge clk) disable iff (rst)
    alloc_irq |-> !failed);
  // R4: BUSY only drops once the packet has no page left
  a_r4_busy_ends_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(!hit_any));
  // R3: a refused allocation touches no page
  a_r3_refused_keeps_map: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE && start_alloc && free_cnt < CNT_W'(ALLOC_PAGES)) |=> $stable(used));
  // R5: the error flag is sticky
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R8: the page map moves only during a walk
  a_r8_idle_map_stable: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |=> $stable(used));
endmodule

// File: rtl/pkt_mmu.sv
module pkt_mmu
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES   = 8,
  parameter int ALLOC_PAGES = 2,
  parameter int TXQ_DEPTH   = 4,
  parameter int CMPL_DEPTH  = 4,
  parameter int CMD_W       = 8,
  localparam int PN_W       = $clog2(NUM_PAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [PN_W-1:0]  pnr,
  output logic             busy,
  output logic             failed,
  output logic [PN_W-1:0]  alloc_pkt,
  output logic             alloc_irq,
  output logic             err_flag,
  output logic             tx_ovf,
  input  logic             tx_pop,
  output logic [PN_W-1:0]  tx_head,
  output logic             tx_empty,
  input  logic             cmpl_push,
  input  logic [PN_W-1:0]  cmpl_din,
  input  logic             cmpl_rd,
  output logic [PN_W-1:0]  cmpl_head,
  output logic             cmpl_empty
);
  logic             wr_q;
  logic [2:0]       op_q;
  logic             exec, go_alloc, go_free, go_enq, go_clr;
  logic             tx_full, cmpl_full;

  // the command is taken on the falling strobe, with the last word seen
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      op_q <= '0;
    end else begin
      wr_q <= cmd_wr;
      if (cmd_wr) op_q <= cmd_wdata[CMD_W-1 -: 3];
    end
  end

  assign exec     = wr_q && !cmd_wr;
  assign go_alloc = exec && (op_q == OP_ALLOC);
  assign go_free  = exec && (op_q == OP_FREE);
  assign go_enq   = exec && (op_q == OP_ENQ);
  assign go_clr   = exec && (op_q == OP_QCLR);

  always_ff @(posedge clk) begin
    if (rst)                    tx_ovf <= 1'b0;
    else if (go_enq && tx_full) tx_ovf <= 1'b1;
  end

  pkt_mmu_pages #(.NUM_PAGES(NUM_PAGES), .ALLOC_PAGES(ALLOC_PAGES)) u_pages (
    .clk(clk), .rst(rst),
    .start_alloc(go_alloc), .start_free(go_free), .free_pkt(pnr),
    .busy(busy), .failed(failed), .alloc_pkt(alloc_pkt),
    .alloc_irq(alloc_irq), .err(err_flag)
  );

  pkt_mmu_fifo #(.W(PN_W), .DEPTH(TXQ_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(go_clr),
    .push(go_enq), .din(pnr), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  pkt_mmu_fifo #(.W(PN_W), .DEPTH(CMPL_DEPTH)) u_cmplq (
    .clk(clk), .rst(rst), .clr(go_clr),
    .push(cmpl_push), .din(cmpl_din), .pop(cmpl_rd),
    .dout(cmpl_head), .empty(cmpl_empty), .full(cmpl_full)
  );

  // R6: an accepted enqueue leaves the pending queue non-empty
  a_r6_enq_lands: assert property (@(posedge clk) disable iff (rst)
    go_enq |=> !tx_empty);
  // R7: overflow stays set until reset
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_ovf |=> tx_ovf);
  // R1: nothing starts while the strobe is still high
  a_r1_hold_no_start: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy) |=> !$rose(busy));
  // R9: a push into a non-full completion queue leaves it non-empty
  a_r9_cmpl_lands: assert property (@(posedge clk) disable iff (rst)
    (cmpl_push && !cmpl_full && !go_clr) |=> !cmpl_empty);
endmodule

// File: tb/pkt_mmu_bench.sv
module pkt_mmu_bench;
  localparam int NP = 8;
  localparam int AP = 2;
  localparam int TD = 4;
  localparam int CD = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [PW-1:0] pnr = '0;
  logic busy, failed, alloc_irq, err_flag, tx_ovf, tx_empty, cmpl_empty;
  logic [PW-1:0] alloc_pkt, tx_head, cmpl_head;
  logic tx_pop = 1'b0, cmpl_push = 1'b0, cmpl_rd = 1'b0;
  logic [PW-1:0] cmpl_din = '0;

  always #10 clk = ~clk;

  pkt_mmu u_pkt_mmu (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .pnr(pnr),
    .busy(busy), .failed(failed), .alloc_pkt(alloc_pkt), .alloc_irq(alloc_irq),
    .err_flag(err_flag), .tx_ovf(tx_ovf), .tx_pop(tx_pop), .tx_head(tx_head),
    .tx_empty(tx_empty), .cmpl_push(cmpl_push), .cmpl_din(cmpl_din),
    .cmpl_rd(cmpl_rd), .cmpl_head(cmpl_head), .cmpl_empty(cmpl_empty)
  );

  int vectors = 0, fails = 0, irq_cnt = 0;
  int owner_m [NP];
  int txq_m[$];
  int cq_m[$];
  bit exp_failed = 0, exp_err = 0, exp_ovf = 0;

  always @(negedge clk) if (alloc_irq) irq_cnt++;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int free_cnt_m();
    int n = 0;
    for (int i = 0; i < NP; i++) if (owner_m[i] < 0) n++;
    return n;
  endfunction

  function automatic int lowest_free_m();
    for (int i = 0; i < NP; i++) if (owner_m[i] < 0) return i;
    return -1;
  endfunction

  function automatic int owned_m(int p);
    int n = 0;
    for (int i = 0; i < NP; i++) if (owner_m[i] == p) n++;
    return n;
  endfunction

  // drive a command; returns on the negedge at which the strobe falls
  task automatic issue(logic [2:0] op, int len);
    cmd_wdata = {op, 5'($urandom)};
    cmd_wr = 1'b1;
    @(negedge clk);
    if (len > 1) begin
      chk("R1 failed held", int'(failed), int'(exp_failed));
      chk("R1 busy held", int'(busy), 0);
    end
    repeat (len - 1) @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic do_alloc(int len);
    int prev = irq_cnt;
    bit ok = (free_cnt_m() >= AP);
    int ep = lowest_free_m();
    issue(3'b001, len);
    @(negedge clk);
    chk("R2 failed set on accept", int'(failed), 1);
    repeat (AP) @(negedge clk);
    @(negedge clk);
    if (ok) begin
      for (int k = 0; k < AP; k++) owner_m[lowest_free_m()] = ep;
      chk("R2 failed cleared", int'(failed), 0);
      chk("R2 alloc_pkt", int'(alloc_pkt), ep);
      chk("R2 one irq", irq_cnt, prev + 1);
      exp_failed = 0;
    end else begin
      chk("R3 failed stays", int'(failed), 1);
      chk("R3 no irq", irq_cnt, prev);
      exp_failed = 1;
    end
  endtask

  task automatic do_free(int p, int len);
    int k = owned_m(p);
    pnr = PW'(p);
    issue(3'b101, len);
    @(negedge clk);
    if (k == 0) begin
      exp_err = 1;
      chk("R5 err on unowned", int'(err_flag), 1);
      chk("R5 no busy", int'(busy), 0);
    end else begin
      chk("R4 busy on accept", int'(busy), 1);
      repeat (k) @(negedge clk);
      chk("R4 busy through walk", int'(busy), 1);
      @(negedge clk);
      chk("R4 busy drops", int'(busy), 0);
      for (int i = 0; i < NP; i++) if (owner_m[i] == p) owner_m[i] = -1;
      chk("R5 err unchanged", int'(err_flag), int'(exp_err));
    end
  endtask

  task automatic do_enq(int p, int len);
    pnr = PW'(p);
    issue(3'b110, len);
    @(negedge clk);
    if (txq_m.size() < TD) txq_m.push_back(p);
    else exp_ovf = 1;
    chk("R7 ovf flag", int'(tx_ovf), int'(exp_ovf));
    chk("R6 not empty", int'(tx_empty), 0);
  endtask

  task automatic do_pop();
    if (txq_m.size() == 0) begin
      chk("R6 empty", int'(tx_empty), 1);
    end else begin
      chk("R6 head order", int'(tx_head), txq_m[0]);
      void'(txq_m.pop_front());
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
    end
  endtask

  task automatic do_cpush(int v);
    cmpl_din = PW'(v);
    cmpl_push = 1'b1;
    @(negedge clk);
    cmpl_push = 1'b0;
    if (cq_m.size() < CD) cq_m.push_back(v);
  endtask

  task automatic do_cread();
    if (cq_m.size() == 0) begin
      chk("R9 empty", int'(cmpl_empty), 1);
    end else begin
      chk("R9 head order", int'(cmpl_head), cq_m[0]);
      void'(cq_m.pop_front());
      cmpl_rd = 1'b1;
      @(negedge clk);
      cmpl_rd = 1'b0;
    end
  endtask

  task automatic do_qclr();
    issue(3'b111, 1);
    @(negedge clk);
    chk("R8 pending empty", int'(tx_empty), 1);
    chk("R8 completion empty", int'(cmpl_empty), 1);
    txq_m.delete();
    cq_m.delete();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NP; i++) owner_m[i] = -1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 failed", int'(failed), 0);
    chk("R11 irq", int'(alloc_irq), 0);
    chk("R11 err", int'(err_flag), 0);
    chk("R11 ovf", int'(tx_ovf), 0);
    chk("R11 tx empty", int'(tx_empty), 1);
    chk("R11 cmpl empty", int'(cmpl_empty), 1);

    // R1 long strobe, R2 fill, R3 exhaustion
    do_alloc(3);
    for (int i = 0; i < 3; i++) do_alloc(1 + i % 2);
    do_alloc(2);

    // R10 unused codes while full: no change
    for (int i = 0; i < 4; i++) begin
      logic [2:0] op = (i == 0) ? 3'b000 : (i == 1) ? 3'b010 : (i == 2) ? 3'b011 : 3'b100;
      pnr = 3'd0;
      issue(op, 1);
      @(negedge clk);
      chk("R10 busy", int'(busy), 0);
      chk("R10 failed", int'(failed), int'(exp_failed));
    end
    do_alloc(1);

    // R5 release while a walk is running is dropped
    pnr = 3'd4;
    issue(3'b101, 1);
    @(negedge clk);
    pnr = 3'd6;
    issue(3'b101, 1);
    repeat (4) @(negedge clk);
    chk("R5 err on collision", int'(err_flag), 1);
    chk("R4 busy low after walk", int'(busy), 0);
    exp_err = 1;
    for (int i = 0; i < NP; i++) if (owner_m[i] == 4) owner_m[i] = -1;
    do_alloc(1);
    do_alloc(1);

    // R4 release and reuse, R5 unowned release
    do_free(2, 2);
    do_alloc(1);
    do_free(1, 1);

    // R6/R7 queue fill and overflow
    for (int i = 0; i < TD + 1; i++) do_enq(i + 1, 1);
    for (int i = 0; i < TD; i++) do_pop();
    do_pop();

    // R8 flush keeps pages
    do_enq(5, 1);
    do_cpush(3);
    do_cpush(6);
    do_qclr();
    do_alloc(1);

    // R9 completion order
    do_cpush(1);
    do_cpush(7);
    do_cpush(2);
    for (int i = 0; i < 4; i++) do_cread();

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 7);
      int len = $urandom_range(1, 3);
      case (sel)
        0, 1: do_alloc(len);
        2: do_free($urandom_range(0, NP - 1), len);
        3: do_enq($urandom_range(0, NP - 1), len);
        4: do_pop();
        5: do_cpush($urandom_range(0, NP - 1));
        6: do_cread();
        default: if ($urandom_range(0, 3) == 0) do_qclr(); else do_pop();
      endcase
    end
    finish_run();
  end
endmodule